// File: doc/BRIEF.md
# Strip-Mined Pipelined SIMD Unit

This block runs one vector instruction that may be wider than the hardware. An instruction carries 8, 16 or 32 lanes of 8-bit operand pairs. The hardware has only 8 lane units. Each lane unit is a four-stage pipeline with one clock per stage. The sequencer cuts the instruction into groups of 8 lanes and feeds one group into the pipeline on each clock. As each group leaves the last stage, its results are written back into the lane positions it came from.

Because the groups follow each other through the pipeline, a G-group instruction finishes in 3 + G clocks rather than 4 × G. A caller pulses `start` with the operands and the width code, then waits for the one-clock `done` pulse. The packed result stays on `vec_y` until the next accepted instruction. Only one instruction is in flight at a time.

Top module: `strip_simd_unit`

## Requirements
- R1: Each result lane equals ((a XOR b) rotated left by (b mod 8)) + a, modulo 256, where a and b are that lane's operand bytes.
- R2: Lane i occupies bits [8i+7:8i] of `vec_a`, `vec_b` and `vec_y`. Group g holds lanes 8g to 8g+7, and its results land in those same lane positions.
- R3: The width code `width_sel` selects 0 = 8 lanes (1 group), 1 = 16 lanes (2 groups), 2 = 32 lanes (4 groups) and 3 = 32 lanes (4 groups). Accepting an instruction clears `vec_y` to zero, so after `done` every lane at or above the width reads zero.
- R4: The edge that accepts `start` counts as clock 1. `done` is high after clock 3 + G, which gives 4, 5 and 7 clocks for 1, 2 and 4 groups.
- R5: `done` is high for exactly one cycle per accepted instruction and is never high without one.
- R6: While an instruction is in flight, from its accepting edge until the edge that raises `done`, `start` is ignored and the latched operands are used. A `start` held during the `done` cycle is accepted.
- R7: While reset is asserted, `vec_y` is zero and `done` is low.
- R8: When no instruction is in flight and `start` is low, `vec_y` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| width_sel | input | 2 | Width code: 0 = 8, 1 = 16, 2 or 3 = 32 lanes |
| vec_a | input | 256 | Packed first operands, lane i at bits [8i+7:8i] |
| vec_b | input | 256 | Packed second operands, same layout |
| vec_y | output | 256 | Packed results, same layout |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a new `start` that lands in the very cycle `done` is high. At that moment the last group has only just been written and the pipeline is being refilled. The bench issues instructions back to back, raising the next `start` in the same sample where it sees `done`, and checks both the new latency and the new lane data. A second hard case is a `start` carrying different operands in the middle of a run. The bench injects one and confirms that the results and the clock count still belong to the first instruction. The operation itself is checked against all 65536 operand pairs, packed 32 to an instruction.

// File: rtl/strip_simd_pkg.sv
package strip_simd_pkg;

    // Number of 8-lane groups selected by a width code, capped at the maximum.
    function automatic int groups_for(input logic [1:0] sel, input int max_groups);
        int g;
        g = 1 << sel;
        if (g > max_groups) g = max_groups;
        return g;
    endfunction

endpackage

// File: rtl/strip_lane.sv
// One lane unit: a four-stage pipeline.
// Stage 1 mixes the operands, stage 2 rotates, stage 3 is a plain delay,
// and the stage 4 adder drives y_o for the write-back register in the top.
module strip_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam int SW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  mix1;
        logic [W-1:0]  a1;
        logic [SW-1:0] sh1;
        logic [W-1:0]  rot2;
        logic [W-1:0]  a2;
        logic [W-1:0]  rot3;
        logic [W-1:0]  a3;
    } lane_st_t;

    lane_st_t st_d, st_q;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [SW-1:0] s);
        logic [2*W-1:0] t;
        t = {x, x} << s;
        return t[2*W-1:W];
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.mix1 = a_i ^ b_i;
        st_d.a1   = a_i;
        st_d.sh1  = b_i[SW-1:0];
        st_d.rot2 = rotl(st_q.mix1, st_q.sh1);
        st_d.a2   = st_q.a1;
        st_d.rot3 = st_q.rot2;
        st_d.a3   = st_q.a2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o = st_q.rot3 + st_q.a3;
endmodule

// File: rtl/strip_seq.sv
// Group sequencer: accepts instructions, issues one group per clock and
// carries group tags alongside the lane pipeline so write-back and done line up.
module strip_seq #(
    parameter int MAX_GROUPS = 4,
    parameter int GW         = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    wsel_i,
    output logic          accept_o,
    output logic [GW-1:0] issue_grp_o,
    output logic          wr_en_o,
    output logic [GW-1:0] wr_grp_o,
    output logic          done_o
);
    import strip_simd_pkg::*;

    typedef struct packed {
        logic          busy;
        logic          issuing;
        logic [GW-1:0] nxt;
        logic [GW-1:0] last;
        logic          v1, v2, v3;
        logic          l1, l2, l3;
        logic [GW-1:0] g1, g2, g3;
        logic          done;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic          accept;
    logic          issue;
    logic [GW-1:0] igrp;
    logic          ilast;
    int            ngr;

    always_comb begin
        ngr    = groups_for(wsel_i, MAX_GROUPS);
        accept = start_i && !st_q.busy;
        issue  = accept || st_q.issuing;
        igrp   = accept ? '0 : st_q.nxt;
        ilast  = accept ? (ngr == 1) : (st_q.nxt == st_q.last);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy    = 1'b1;
            st_d.last    = GW'(ngr - 1);
            st_d.issuing = (ngr > 1);
            st_d.nxt     = GW'(1);
        end else if (st_q.issuing) begin
            if (st_q.nxt == st_q.last) st_d.issuing = 1'b0;
            else                        st_d.nxt     = st_q.nxt + GW'(1);
        end

        st_d.v1 = issue;        st_d.g1 = igrp;    st_d.l1 = ilast;
        st_d.v2 = st_q.v1;      st_d.g2 = st_q.g1; st_d.l2 = st_q.l1;
        st_d.v3 = st_q.v2;      st_d.g3 = st_q.g2; st_d.l3 = st_q.l2;

        if (st_q.v3 && st_q.l3) begin
            st_d.done = 1'b1;
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept_o    = accept;
    assign issue_grp_o = igrp;
    assign wr_en_o     = st_q.v3;
    assign wr_grp_o    = st_q.g3;
    assign done_o      = st_q.done;
endmodule

// File: rtl/strip_simd_unit.sv
module strip_simd_unit #(
    parameter int LANE_W    = 8,
    parameter int HW_LANES  = 8,
    parameter int MAX_LANES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    width_sel,
    input  logic [MAX_LANES*LANE_W-1:0]   vec_a,
    input  logic [MAX_LANES*LANE_W-1:0]   vec_b,
    output logic [MAX_LANES*LANE_W-1:0]   vec_y,
    output logic                          done
);
    localparam int VW         = MAX_LANES * LANE_W;
    localparam int MAX_GROUPS = MAX_LANES / HW_LANES;
    localparam int GW         = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1;

    typedef struct packed {
        logic [VW-1:0] opa;
        logic [VW-1:0] opb;
        logic [VW-1:0] res;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          accept;
    logic [GW-1:0] issue_grp;
    logic          wr_en;
    logic [GW-1:0] wr_grp;
    logic [VW-1:0] src_a, src_b;
    logic [LANE_W-1:0] lane_y [HW_LANES];

    strip_seq #(.MAX_GROUPS(MAX_GROUPS), .GW(GW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .wsel_i      (width_sel),
        .accept_o    (accept),
        .issue_grp_o (issue_grp),
        .wr_en_o     (wr_en),
        .wr_grp_o    (wr_grp),
        .done_o      (done)
    );

    // The first group comes straight from the ports; later groups from the latch.
    assign src_a = accept ? vec_a : st_q.opa;
    assign src_b = accept ? vec_b : st_q.opb;

    for (genvar k = 0; k < HW_LANES; k++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        assign la = src_a[(int'(issue_grp) * HW_LANES + k) * LANE_W +: LANE_W];
        assign lb = src_b[(int'(issue_grp) * HW_LANES + k) * LANE_W +: LANE_W];
        strip_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (la),
            .b_i   (lb),
            .y_o   (lane_y[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.opa = vec_a;
            st_d.opb = vec_b;
            st_d.res = '0;
        end
        if (wr_en) begin
            for (int k = 0; k < HW_LANES; k++)
                st_d.res[(int'(wr_grp) * HW_LANES + k) * LANE_W +: LANE_W] = lane_y[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_y = st_q.res;
endmodule

// File: rtl/strip_simd_chk.sv
module strip_simd_chk #(
    parameter int VW         = 256,
    parameter int MAX_GROUPS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    width_sel,
    input logic          done,
    input logic [VW-1:0] vec_y
);
    import strip_simd_pkg::*;

    logic bsy;
    int   cnt;
    int   exp_clk;
    logic acc;

    assign acc = start && (!bsy || done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsy     <= 1'b0;
            cnt     <= 0;
            exp_clk <= 0;
        end else if (acc) begin
            bsy     <= 1'b1;
            cnt     <= 1;
            exp_clk <= 3 + groups_for(width_sel, MAX_GROUPS);
        end else begin
            if (done) bsy <= 1'b0;
            if (bsy)  cnt <= cnt + 1;
        end
    end

    // R4, R5: done only ends a tracked instruction, at clock 3 + groups
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bsy && cnt == exp_clk));

    // R5: done lasts a single cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: acceptance clears the result
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (vec_y == '0));

    // R8: the result holds while idle
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bsy && !start) |=> $stable(vec_y));
endmodule

bind strip_simd_unit strip_simd_chk #(
    .VW         (MAX_LANES * LANE_W),
    .MAX_GROUPS (MAX_LANES / HW_LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .width_sel (width_sel),
    .done      (done),
    .vec_y     (vec_y)
);

// File: tb/sim_strip_simd_unit.sv
`timescale 1ns/1ps
module sim_strip_simd_unit;
    localparam int LW = 8;
    localparam int NL = 32;
    localparam int VW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    width_sel = 2'd0;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [VW-1:0] vec_y;
    logic          done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    strip_simd_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .width_sel (width_sel),
        .vec_a     (vec_a),
        .vec_b     (vec_b),
        .vec_y     (vec_y),
        .done      (done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b);
        logic [7:0]  x;
        int          s;
        logic [15:0] w;
        x = a ^ b;
        s = b % 8;
        w = {8'h00, x} << s;
        return (w[7:0] | w[15:8]) + a;
    endfunction

    function automatic int lanes_of(input logic [1:0] sel);
        return (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Issue one instruction; when poke is set, a rival start with other data
    // is applied in clock 2. Returns at the negedge where done is seen.
    task automatic run(input logic [1:0] sel, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input bit poke);
        int n;
        int nl;
        int exp_n;
        nl    = lanes_of(sel);
        exp_n = 3 + nl / 8;
        width_sel = sel;
        vec_a = a;
        vec_b = b;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 20) begin
            if (poke && n == 1) begin
                start = 1'b1;
                vec_a = ~a;
                vec_b = b ^ {NL{8'h5a}};
                width_sel = 2'd0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
        end
        // R4 latency, and R6 rival start must not shorten or restart it
        chk(n == exp_n, poke ? "R6 latency under rival start" : "R4 completion clock", n, exp_n);
        for (int i = 0; i < NL; i++) begin
            logic [7:0] e;
            e = (i < nl) ? model(a[i*8 +: 8], b[i*8 +: 8]) : 8'h00;
            // R1 value, R2 placement, R3 zero above width
            chk(vec_y[i*8 +: 8] == e, (i < nl) ? "R1/R2 lane result" : "R3 lane above width",
                vec_y[i*8 +: 8], e);
        end
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [VW-1:0] held;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(vec_y == '0, "R7 result in reset", vec_y[63:0], 0);
        chk(done == 1'b0, "R7 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: every width code, random operands, with idle gaps
        for (int s = 0; s < 4; s++) begin
            run(s[1:0], rnd_vec(), rnd_vec(), 1'b0);
            @(negedge clk);
            chk(done == 1'b0, "R5 done single cycle", done, 0);
        end

        // R6: a rival start mid-flight is ignored
        run(2'd2, rnd_vec(), rnd_vec(), 1'b1);
        run(2'd1, rnd_vec(), rnd_vec(), 1'b1);
        @(negedge clk);

        // R8: result holds while idle and start stays low
        held = vec_y;
        vec_a = rnd_vec();
        vec_b = rnd_vec();
        width_sel = 2'd2;
        repeat (6) @(negedge clk);
        chk(vec_y == held, "R8 idle hold", vec_y[63:0], held[63:0]);
        chk(done == 1'b0, "R5 no done while idle", done, 0);

        // R6 second half: back-to-back, start raised in the done cycle
        run(2'd0, rnd_vec(), rnd_vec(), 1'b0);
        run(2'd2, rnd_vec(), rnd_vec(), 1'b0);
        run(2'd1, rnd_vec(), rnd_vec(), 1'b0);

        // R1: all 65536 operand pairs, 32 per instruction, back to back
        for (int blk = 0; blk < 2048; blk++) begin
            logic [VW-1:0] a, b;
            for (int l = 0; l < 32; l++) begin
                int p;
                p = blk * 32 + l;
                a[l*8 +: 8] = p[15:8];
                b[l*8 +: 8] = p[7:0];
            end
            run(2'd2, a, b, 1'b0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R5 done drops after last", done, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule